// File: doc/BRIEF.md
# Shared Converter Measurement Scheduler

This block decides, conversion by conversion, what a single shared converter measures on behalf of a group of switched ports. When software asks for nothing, it sweeps the drain voltage of each port in turn. The outcome of every sweep step refreshes two per-port flags: power good, meaning the drain sits low, and FET short, meaning the drain is low although the port is switched off.

Software may request one measurement: a detection on a chosen port, a port voltage, the input voltage or the temperature. That request wins the converter at the next measurement boundary, ahead of the sweep. A request that arrives while a conversion is running waits in a single holding slot. A detection takes 16 sample windows and returns their average. Each window has one of two lengths, picked by a line-frequency select, so that the 16 windows together span one whole number of mains cycles at either 50 Hz or 60 Hz. Every finished request is reported with a one-cycle done pulse that carries the measurement type, the port and the result. The analog front end presents a sample on `adc_data_i`, and the scheduler takes it on each `sample_strobe_o`.

Top module: `conv_sched`

## Requirements
- R1: While `rst_ni` is low, `meas_valid_o`, `done_o`, `pgood_o` and `fet_short_o` are all 0 and `cmd_ready_o` is 1.
- R2: With no request waiting, successive measurements are drain scans (`meas_kind_o` = 4) of ports 0, 1, ..., NUM_PORTS-1, 0, .... After a request has been served, the sweep resumes at the port after the last drain scan that completed.
- R3: A request that is accepted or held is the next measurement to start, ahead of any drain scan. Requests start in the order they were accepted.
- R4: The scheduler holds at most one request. From the cycle after a request is accepted during a running conversion until that request starts, `cmd_ready_o` is 0.
- R5: A drain scan, port-voltage, input-voltage or temperature measurement lasts CONV_CYCLES cycles and takes exactly one sample. Measurements follow one another with no idle cycle.
- R6: A detection (`cmd_type_i` = 0) takes DET_SAMPLES samples. Each sample window lasts DET_SAMP_50HZ cycles when `mains_sel_i` was 0 at the start of the detection, and DET_SAMP_60HZ cycles when it was 1. Later changes of `mains_sel_i` have no effect on a detection already running.
- R7: The result of a detection is the sum of its samples divided by DET_SAMPLES and rounded down. Any other measurement returns its single sample.
- R8: In the cycle after the last sample of a request, `done_o` is high for exactly one cycle. `done_type_o` carries the request code (0 detection, 1 port voltage, 2 input voltage, 3 temperature), `done_port_o` the port and `done_data_o` the result.
- R9: In the cycle after a drain scan of port p samples, `pgood_o[p]` shows whether that sample is below PG_THRESH.
- R10: In the same cycle, `fet_short_o[p]` shows whether that sample is below SHORT_THRESH while `port_en_i[p]` is 0. Status bits of every other port are unchanged, and no status bit changes at any other time.
- R11: A drain scan never raises `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mains_sel_i | input | 1 | Line-frequency select for detection timing: 0 for 50 Hz, 1 for 60 Hz |
| port_en_i | input | NUM_PORTS | Port switched-on flags, used by the FET-short flag |
| cmd_valid_i | input | 1 | Measurement request valid |
| cmd_type_i | input | 2 | Request code: 0 detection, 1 port voltage, 2 input voltage, 3 temperature |
| cmd_port_i | input | PW | Port for the request |
| cmd_ready_o | output | 1 | Holding slot free; a request is taken when valid and ready are both high |
| meas_valid_o | output | 1 | Converter busy with a measurement |
| meas_kind_o | output | 3 | Current measurement: request code, or 4 for a drain scan |
| meas_port_o | output | PW | Port of the current measurement |
| sample_strobe_o | output | 1 | Last cycle of a sample window; `adc_data_i` is taken at the clock edge that ends this cycle |
| adc_data_i | input | DATA_W | Converter sample |
| done_o | output | 1 | Request finished, one-cycle pulse |
| done_type_o | output | 2 | Code of the finished request |
| done_port_o | output | PW | Port of the finished request |
| done_data_o | output | DATA_W | Result of the finished request |
| pgood_o | output | NUM_PORTS | Per-port power-good flags |
| fet_short_o | output | NUM_PORTS | Per-port FET-short flags |

## Verification
A measurement starts at the clock edge that ends the final strobe of the one before it. The bench therefore compares kind and port on the first falling edge at which a new measurement shows. It counts cycles from that edge up to the final strobe, and compares the count with CONV_CYCLES or with 16 times the sample window in force. The done pulse and the status flags fall due one cycle after the final strobe, so they are compared on the following falling edge. The mains select and the port enables are recorded at the edges where the design takes them. A holding slot is modelled by a queue of accepted requests, and `cmd_ready_o` must stay low on every falling edge while that queue is not empty.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;
  typedef enum logic [2:0] {
    KIND_DET   = 3'd0,
    KIND_PORTV = 3'd1,
    KIND_VIN   = 3'd2,
    KIND_TEMP  = 3'd3,
    KIND_DRAIN = 3'd4
  } meas_kind_e;
endpackage

// File: rtl/conv_sched_arb.sv
module conv_sched_arb
  import conv_sched_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_type_i,
  input  logic [PW-1:0] cmd_port_i,
  input  logic          scan_done_i,
  input  logic [PW-1:0] scan_port_i,
  output logic          cmd_ready_o,
  output meas_kind_e    nxt_kind_o,
  output logic [PW-1:0] nxt_port_o
);
  localparam logic [PW-1:0] LAST_PORT = PW'(NUM_PORTS - 1);

  logic          pend_q;
  meas_kind_e    pend_kind_q;
  logic [PW-1:0] pend_port_q;
  logic [PW-1:0] scan_ptr_q, scan_next;
  logic          accept;

  assign cmd_ready_o = !pend_q;
  assign accept      = cmd_valid_i && !pend_q;

  // resume after the last completed scan
  assign scan_next = !scan_done_i ? scan_ptr_q :
                     (scan_port_i == LAST_PORT) ? '0 : scan_port_i + 1'b1;

  always_comb begin
    if (pend_q) begin
      nxt_kind_o = pend_kind_q;
      nxt_port_o = pend_port_q;
    end else if (accept) begin
      nxt_kind_o = meas_kind_e'({1'b0, cmd_type_i});
      nxt_port_o = cmd_port_i;
    end else begin
      nxt_kind_o = KIND_DRAIN;
      nxt_port_o = scan_next;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_kind_q <= KIND_DET;
      pend_port_q <= '0;
      scan_ptr_q  <= '0;
    end else begin
      scan_ptr_q <= scan_next;
      if (accept && !load_i) begin
        pend_q      <= 1'b1;
        pend_kind_q <= meas_kind_e'({1'b0, cmd_type_i});
        pend_port_q <= cmd_port_i;
      end else if (load_i && pend_q) begin
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/conv_sched_timer.sv
module conv_sched_timer #(
  parameter int CONV_CYCLES   = 100000,
  parameter int DET_SAMP_50HZ = 125000,
  parameter int DET_SAMP_60HZ = 104167,
  parameter int DET_SAMPLES   = 16,
  localparam int MAX_A = (CONV_CYCLES > DET_SAMP_50HZ) ? CONV_CYCLES : DET_SAMP_50HZ,
  localparam int MAX_W = (MAX_A > DET_SAMP_60HZ) ? MAX_A : DET_SAMP_60HZ,
  localparam int CW    = $clog2(MAX_W + 1),
  localparam int SW    = (DET_SAMPLES > 1) ? $clog2(DET_SAMPLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic is_det_i,
  input  logic mains_i,
  output logic active_o,
  output logic strobe_o,
  output logic last_o
);
  localparam logic [CW-1:0] LEN_CONV = CW'(CONV_CYCLES - 1);
  localparam logic [CW-1:0] LEN_50   = CW'(DET_SAMP_50HZ - 1);
  localparam logic [CW-1:0] LEN_60   = CW'(DET_SAMP_60HZ - 1);
  localparam logic [SW-1:0] LAST_SMP = SW'(DET_SAMPLES - 1);

  logic [CW-1:0] cnt_q;
  logic [SW-1:0] smp_q;
  logic          det_q, mains_q;

  function automatic logic [CW-1:0] win_len(input logic det, input logic mains);
    return det ? (mains ? LEN_60 : LEN_50) : LEN_CONV;
  endfunction

  assign strobe_o = active_o && (cnt_q == '0);
  assign last_o   = strobe_o && (!det_q || smp_q == LAST_SMP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      cnt_q    <= '0;
      smp_q    <= '0;
      det_q    <= 1'b0;
      mains_q  <= 1'b0;
    end else if (load_i) begin
      active_o <= 1'b1;
      cnt_q    <= win_len(is_det_i, mains_i);
      smp_q    <= '0;
      det_q    <= is_det_i;
      mains_q  <= mains_i;
    end else if (active_o) begin
      if (cnt_q == '0) begin
        cnt_q <= win_len(det_q, mains_q);
        smp_q <= smp_q + 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/conv_sched_acc.sv
module conv_sched_acc #(
  parameter int DATA_W      = 10,
  parameter int DET_SAMPLES = 16,
  localparam int SHIFT = $clog2(DET_SAMPLES),
  localparam int AW    = DATA_W + SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              last_i,
  input  logic              is_det_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] result_o
);
  logic [AW-1:0] acc_q, sum;

  assign sum      = acc_q + AW'(data_i);
  // DET_SAMPLES is a power of two: divide by shift
  assign result_o = is_det_i ? DATA_W'(sum >> SHIFT) : data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (strobe_i) acc_q <= last_i ? '0 : sum;
  end
endmodule

// File: rtl/conv_sched_status.sv
module conv_sched_status #(
  parameter int NUM_PORTS    = 4,
  parameter int DATA_W       = 10,
  parameter int PG_THRESH    = 200,
  parameter int SHORT_THRESH = 64,
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 update_i,
  input  logic [PW-1:0]        port_i,
  input  logic [DATA_W-1:0]    sample_i,
  input  logic [NUM_PORTS-1:0] port_en_i,
  output logic [NUM_PORTS-1:0] pgood_o,
  output logic [NUM_PORTS-1:0] fet_short_o
);
  localparam logic [DATA_W-1:0] PG_TH = DATA_W'(PG_THRESH);
  localparam logic [DATA_W-1:0] SH_TH = DATA_W'(SHORT_THRESH);

  logic below_pg, below_sh;
  assign below_pg = sample_i < PG_TH;
  assign below_sh = sample_i < SH_TH;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pgood_o[p]     <= 1'b0;
        fet_short_o[p] <= 1'b0;
      end else if (update_i && port_i == PW'(p)) begin
        pgood_o[p]     <= below_pg;
        fet_short_o[p] <= below_sh && !port_en_i[p];
      end
    end
  end
endmodule

// File: rtl/conv_sched.sv
module conv_sched
  import conv_sched_pkg::*;
#(
  parameter int NUM_PORTS     = 4,
  parameter int DATA_W        = 10,
  parameter int CONV_CYCLES   = 100000,
  parameter int DET_SAMP_50HZ = 125000,
  parameter int DET_SAMP_60HZ = 104167,
  parameter int DET_SAMPLES   = 16,
  parameter int PG_THRESH     = 200,
  parameter int SHORT_THRESH  = 64,
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mains_sel_i,
  input  logic [NUM_PORTS-1:0] port_en_i,
  input  logic                 cmd_valid_i,
  input  logic [1:0]           cmd_type_i,
  input  logic [PW-1:0]        cmd_port_i,
  output logic                 cmd_ready_o,
  output logic                 meas_valid_o,
  output logic [2:0]           meas_kind_o,
  output logic [PW-1:0]        meas_port_o,
  output logic                 sample_strobe_o,
  input  logic [DATA_W-1:0]    adc_data_i,
  output logic                 done_o,
  output logic [1:0]           done_type_o,
  output logic [PW-1:0]        done_port_o,
  output logic [DATA_W-1:0]    done_data_o,
  output logic [NUM_PORTS-1:0] pgood_o,
  output logic [NUM_PORTS-1:0] fet_short_o
);
  logic          active, strobe, last, load, scan_done;
  meas_kind_e    nxt_kind, cur_kind_q;
  logic [PW-1:0] nxt_port, cur_port_q;
  logic [DATA_W-1:0] result;

  assign load      = !active || last;
  assign scan_done = last && (cur_kind_q == KIND_DRAIN);

  conv_sched_arb #(.NUM_PORTS(NUM_PORTS)) u_arb (
    .clk_i, .rst_ni,
    .load_i      (load),
    .cmd_valid_i,
    .cmd_type_i,
    .cmd_port_i,
    .scan_done_i (scan_done),
    .scan_port_i (cur_port_q),
    .cmd_ready_o,
    .nxt_kind_o  (nxt_kind),
    .nxt_port_o  (nxt_port)
  );

  conv_sched_timer #(
    .CONV_CYCLES  (CONV_CYCLES),
    .DET_SAMP_50HZ(DET_SAMP_50HZ),
    .DET_SAMP_60HZ(DET_SAMP_60HZ),
    .DET_SAMPLES  (DET_SAMPLES)
  ) u_timer (
    .clk_i, .rst_ni,
    .load_i   (load),
    .is_det_i (nxt_kind == KIND_DET),
    .mains_i  (mains_sel_i),
    .active_o (active),
    .strobe_o (strobe),
    .last_o   (last)
  );

  conv_sched_acc #(.DATA_W(DATA_W), .DET_SAMPLES(DET_SAMPLES)) u_acc (
    .clk_i, .rst_ni,
    .strobe_i (strobe),
    .last_i   (last),
    .is_det_i (cur_kind_q == KIND_DET),
    .data_i   (adc_data_i),
    .result_o (result)
  );

  conv_sched_status #(
    .NUM_PORTS   (NUM_PORTS),
    .DATA_W      (DATA_W),
    .PG_THRESH   (PG_THRESH),
    .SHORT_THRESH(SHORT_THRESH)
  ) u_status (
    .clk_i, .rst_ni,
    .update_i   (scan_done),
    .port_i     (cur_port_q),
    .sample_i   (adc_data_i),
    .port_en_i,
    .pgood_o,
    .fet_short_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_kind_q <= KIND_DRAIN;
      cur_port_q <= '0;
    end else if (load) begin
      cur_kind_q <= nxt_kind;
      cur_port_q <= nxt_port;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      done_type_o <= '0;
      done_port_o <= '0;
      done_data_o <= '0;
    end else begin
      done_o <= last && (cur_kind_q != KIND_DRAIN);
      if (last && cur_kind_q != KIND_DRAIN) begin
        done_type_o <= 2'(cur_kind_q);
        done_port_o <= cur_port_q;
        done_data_o <= result;
      end
    end
  end

  assign meas_valid_o    = active;
  assign meas_kind_o     = 3'(cur_kind_q);
  assign meas_port_o     = cur_port_q;
  assign sample_strobe_o = strobe;
endmodule

// File: rtl/conv_sched_chk.sv
module conv_sched_chk #(
  parameter int NUM_PORTS = 4,
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cmd_valid_i,
  input logic                 cmd_ready_o,
  input logic                 meas_valid_o,
  input logic [2:0]           meas_kind_o,
  input logic [PW-1:0]        meas_port_o,
  input logic                 sample_strobe_o,
  input logic                 done_o,
  input logic [NUM_PORTS-1:0] pgood_o,
  input logic [NUM_PORTS-1:0] fet_short_o
);
  logic scan_end;
  assign scan_end = meas_valid_o && sample_strobe_o && meas_kind_o == 3'd4;

  p_scan_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_end |=> (meas_kind_o != 3'd4) ||
      (meas_port_o == (($past(meas_port_o) == PW'(NUM_PORTS - 1)) ? '0 : $past(meas_port_o) + 1'b1)));

  p_hold_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && meas_valid_o && !sample_strobe_o) |=> !cmd_ready_o);

  p_steady_meas_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_valid_o && !sample_strobe_o) |=> $stable(meas_kind_o) && $stable(meas_port_o));

  p_no_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_valid_o |=> meas_valid_o);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_status_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_end |=> $stable(pgood_o) && $stable(fet_short_o));

  p_scan_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_end |=> !done_o);
endmodule

bind conv_sched conv_sched_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cmd_valid_i    (cmd_valid_i),
  .cmd_ready_o    (cmd_ready_o),
  .meas_valid_o   (meas_valid_o),
  .meas_kind_o    (meas_kind_o),
  .meas_port_o    (meas_port_o),
  .sample_strobe_o(sample_strobe_o),
  .done_o         (done_o),
  .pgood_o        (pgood_o),
  .fet_short_o    (fet_short_o)
);

// File: tb/conv_sched_tb.sv
module conv_sched_tb;
  localparam int NP = 4, PW = 2, DW = 10;
  localparam int CONV = 20, S50 = 25, S60 = 21, NDET = 16;
  localparam int PG_TH = 200, SH_TH = 64;

  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic rst_ni = 1'b0, mains_sel_i = 1'b0, cmd_valid_i = 1'b0;
  logic [NP-1:0] port_en_i = '0;
  logic [1:0] cmd_type_i = '0;
  logic [PW-1:0] cmd_port_i = '0;
  logic [DW-1:0] adc_data_i = '0;
  logic cmd_ready_o, meas_valid_o, sample_strobe_o, done_o;
  logic [2:0] meas_kind_o;
  logic [PW-1:0] meas_port_o, done_port_o;
  logic [1:0] done_type_o;
  logic [DW-1:0] done_data_o;
  logic [NP-1:0] pgood_o, fet_short_o;

  conv_sched #(
    .NUM_PORTS(NP), .DATA_W(DW), .CONV_CYCLES(CONV), .DET_SAMP_50HZ(S50),
    .DET_SAMP_60HZ(S60), .DET_SAMPLES(NDET), .PG_THRESH(PG_TH), .SHORT_THRESH(SH_TH)
  ) u_dut (.*);

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int kind, input bit mains);
    return (kind == 0) ? NDET * (mains ? S60 : S50) : CONV;
  endfunction

  function automatic int exp_result(input int kind, input int sum, input int smp);
    return (kind == 0) ? sum / NDET : smp;
  endfunction

  // accepted-but-not-started requests
  int q_kind[64], q_port[64];
  int q_wr = 0, q_rd = 0;
  bit mains_edge;
  logic [NP-1:0] pen_edge;

  always @(posedge clk_i) begin
    if (rst_ni && cmd_valid_i && cmd_ready_o) begin
      q_kind[q_wr % 64] = int'(cmd_type_i);
      q_port[q_wr % 64] = int'(cmd_port_i);
      q_wr++;
    end
    mains_edge <= mains_sel_i;
    pen_edge   <= port_en_i;
  end

  bit in_meas = 0, ck_pend = 0;
  int m_kind, m_port, m_len, m_n, cyc, nsmp, sum, last_smp, scan_ptr = 0;
  logic [NP-1:0] pg_m = '0, fs_m = '0;

  always @(negedge clk_i) begin
    logic [DW-1:0] v;
    v = ($urandom_range(0, 1) == 0) ? DW'($urandom_range(0, 255)) : DW'($urandom);
    adc_data_i = v;
    if (!rst_ni) begin
      in_meas = 0; ck_pend = 0; scan_ptr = 0; pg_m = '0; fs_m = '0;
    end else begin
      if (ck_pend) begin
        ck_pend = 0;
        if (m_kind == 4) begin
          check(done_o == 1'b0, "R11 scan raised done", int'(done_o), 0);
          pg_m[m_port] = last_smp < PG_TH;
          fs_m[m_port] = (last_smp < SH_TH) && !pen_edge[m_port];
          check(pgood_o == pg_m, "R9 pgood", int'(pgood_o), int'(pg_m));
          check(fet_short_o == fs_m, "R10 fet_short", int'(fet_short_o), int'(fs_m));
        end else begin
          check(done_o == 1'b1, "R8 done pulse", int'(done_o), 1);
          check(int'(done_type_o) == m_kind, "R8 done type", int'(done_type_o), m_kind);
          check(int'(done_port_o) == m_port, "R8 done port", int'(done_port_o), m_port);
          check(int'(done_data_o) == exp_result(m_kind, sum, last_smp),
                (m_kind == 0) ? "R7 detection average" : "R7 single result",
                int'(done_data_o), exp_result(m_kind, sum, last_smp));
        end
      end
      if (!in_meas && meas_valid_o) begin
        if (q_rd != q_wr) begin
          m_kind = q_kind[q_rd % 64]; m_port = q_port[q_rd % 64]; q_rd++;
          check(int'(meas_kind_o) == m_kind, "R3 request kind", int'(meas_kind_o), m_kind);
          check(int'(meas_port_o) == m_port, "R3 request port", int'(meas_port_o), m_port);
        end else begin
          m_kind = 4; m_port = scan_ptr;
          check(int'(meas_kind_o) == 4, "R2 scan kind", int'(meas_kind_o), 4);
          check(int'(meas_port_o) == m_port, "R2 scan port", int'(meas_port_o), m_port);
        end
        m_len = exp_len(m_kind, mains_edge);
        m_n = (m_kind == 0) ? NDET : 1;
        in_meas = 1; cyc = 0; nsmp = 0; sum = 0;
      end
      if (in_meas) begin
        cyc++;
        if (sample_strobe_o) begin
          nsmp++; sum += int'(v); last_smp = int'(v);
          if (nsmp == m_n) begin
            check(cyc == m_len, (m_kind == 0) ? "R6 detection length" : "R5 conversion length",
                  cyc, m_len);
            if (m_kind == 4) scan_ptr = (m_port + 1) % NP;
            in_meas = 0; ck_pend = 1;
          end
        end
      end
      if (q_rd != q_wr)
        check(cmd_ready_o == 1'b0, "R4 holding slot full", int'(cmd_ready_o), 0);
    end
  end

  task automatic issue(input int kind, input int port);
    @(negedge clk_i);
    while (!cmd_ready_o) @(negedge clk_i);
    cmd_valid_i = 1'b1;
    cmd_type_i  = 2'(kind);
    cmd_port_i  = PW'(port);
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk_i);
    check(meas_valid_o == 1'b0, "R1 reset meas_valid", int'(meas_valid_o), 0);
    check(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
    check(pgood_o == '0, "R1 reset pgood", int'(pgood_o), 0);
    check(fet_short_o == '0, "R1 reset fet_short", int'(fet_short_o), 0);
    check(cmd_ready_o == 1'b1, "R1 reset ready", int'(cmd_ready_o), 1);
    rst_ni = 1'b1;
    port_en_i = 4'b0101;
    repeat (10 * CONV) @(negedge clk_i);      // R2 plain sweep
    issue(0, 2);                              // R6 50 Hz detection
    issue(1, 1);                              // R4 held behind it
    repeat (5) @(negedge clk_i);
    mains_sel_i = 1'b1;                       // R6 must not affect the running detection
    repeat (NDET * S50 + 3 * CONV) @(negedge clk_i);
    issue(0, 3);                              // R6 60 Hz detection
    repeat (NDET * S60 + 2 * CONV) @(negedge clk_i);
    issue(2, 0); issue(3, 1); issue(1, 3);    // R3 back-to-back requests
    for (int i = 0; i < 40; i++) begin
      repeat ($urandom_range(0, 3 * CONV)) @(negedge clk_i);
      port_en_i   = NP'($urandom);
      mains_sel_i = 1'($urandom);
      issue($urandom_range(0, 3), $urandom_range(0, NP - 1));
    end
    repeat (NDET * S50 + 8 * CONV) @(negedge clk_i);
    finished = 1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
      $finish;
    end
  end
endmodule